// File: doc/BRIEF.md
# Interrupt Request Masking and Steering

This block collects 32 level-sensitive, active-high interrupt lines and ORs each one with the matching bit of a software request register. The merged word is reported unmasked as raw status. It is then gated by an enable register and split into two groups. The fast group is bits 3 to 0. The general group is bits 31 to 4. Each group has its own status vector, a 5-bit identifier for its winning request, and an acknowledge pulse back toward the peripherals.

A bus-side register port writes the two registers through three strobes that share one data word. One strobe sets software request bits. One strobe clears software request bits. One strobe sets enable bits. Bus decoding and vector selection belong to neighbouring blocks.

Each group runs a three-state handshake machine:
- Idle: no request was seen at the last edge.
- Pending: a request was seen.
- Acknowledge: the CPU side has taken the group's request.

Its transitions are:
- Idle to Pending when any masked request in the group is active.
- Pending to Acknowledge on a take strobe.
- Pending to Idle when the group empties without a take.
- Acknowledge to Pending if requests remain.
- Acknowledge to Idle if no requests remain.

The acknowledge output is high exactly while the machine is in Acknowledge.

Top module: `irq_steer_top`

## Requirements
- R1: `raw_status` equals `irq_in` bitwise ORed with the software request register, before any enable masking.
- R2: When `swi_set_stb` is high at a clock edge, every 1 bit of `reg_wdata` sets the matching software request bit. Every 0 bit leaves its bit unchanged.
- R3: When `swi_clr_stb` is high at a clock edge, every 1 bit of `reg_wdata` clears the matching software request bit. If both software strobes are high in the same cycle, a bit written as 1 ends up set.
- R4: When `en_set_stb` is high at a clock edge, every 1 bit of `reg_wdata` sets the matching enable bit. Writing a 0 bit never clears a stored enable.
- R5: While `rst` is high, the enable and software request registers clear to zero and both acknowledges are low. Every interrupt therefore starts disabled.
- R6: `fast_status` equals the masked word's bits 3:0. `gen_status` equals the masked word's bits 31:4. Here the masked word is `raw_status & en_value`.
- R7: `fast_id` is the lowest-numbered active bit of the masked fast group (0 to 3). `gen_id` is the absolute bit number, 4 to 31, of the lowest active bit of the masked general group. An empty group gives ID 0.
- R8: Suppose a group's take input is high while its machine is in Pending, meaning the group held a request at the previous edge. That group's acknowledge is then high for exactly the next single cycle.
- R9: A take input arriving while its group is in Idle is ignored. This includes the cycle in which a first request appears. No acknowledge follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Active-high synchronous reset |
| irq_in | input | 32 | Level-sensitive interrupt lines, active high |
| reg_wdata | input | 32 | Write data shared by the three register strobes |
| swi_set_stb | input | 1 | Set software request bits where `reg_wdata` is 1 |
| swi_clr_stb | input | 1 | Clear software request bits where `reg_wdata` is 1 |
| en_set_stb | input | 1 | Set enable bits where `reg_wdata` is 1 |
| fast_take | input | 1 | CPU side has taken the fast-group request |
| gen_take | input | 1 | CPU side has taken the general-group request |
| raw_status | output | 32 | Hardware OR software requests before masking |
| swi_value | output | 32 | Current software request register |
| en_value | output | 32 | Current enable register |
| fast_status | output | 4 | Masked fast-group requests |
| gen_status | output | 28 | Masked general-group requests |
| fast_id | output | 5 | Lowest active fast request index |
| gen_id | output | 5 | Lowest active general request bit number |
| fast_ack | output | 1 | One-cycle acknowledge for the fast group |
| gen_ack | output | 1 | One-cycle acknowledge for the general group |

## Verification
The hardest situation to reach from the ports is a take strobe that coincides with the first edge at which a group gains a request. The machine is still in Idle at that edge, so the strobe must be ignored (R9). The bench drives the new request and the take strobe in the same half cycle, checks that no acknowledge follows, and then repeats the take one cycle later to show the acknowledge now appears. Because enables can only be set, each stimulus row starts from a reset so that the mask pattern of one row does not leak into the next.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
    localparam int unsigned NUM_SRC = 32;
    localparam int unsigned FAST_N  = 4;
    localparam int unsigned ID_W    = 5;

    typedef enum logic [1:0] {
        GRP_IDLE = 2'd0,
        GRP_PEND = 2'd1,
        GRP_ACK  = 2'd2
    } grp_state_e;
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] wdata,
    input  logic         swi_set,
    input  logic         swi_clr,
    input  logic         en_set,
    output logic [N-1:0] swi_q,
    output logic [N-1:0] en_q
);
    logic [N-1:0] set_mask;
    logic [N-1:0] clr_mask;

    always_comb begin
        set_mask = swi_set ? wdata : '0;
        clr_mask = swi_clr ? wdata : '0;
    end

    // clear applied first, then set, so a set wins on a shared bit
    always_ff @(posedge clk) begin
        if (rst) begin
            swi_q <= '0;
            en_q  <= '0;
        end else begin
            swi_q <= (swi_q & ~clr_mask) | set_mask;
            if (en_set) en_q <= en_q | wdata;
        end
    end

    assert_en_no_clear_R4: assert property (@(posedge clk) disable iff (rst)
        ((en_q & $past(en_q)) == $past(en_q)));

    assert_swi_rise_needs_set_R2: assert property (@(posedge clk) disable iff (rst)
        ((swi_q & ~$past(swi_q)) != '0) |-> $past(swi_set));

    assert_swi_fall_needs_clr_R3: assert property (@(posedge clk) disable iff (rst)
        ((~swi_q & $past(swi_q)) != '0) |-> $past(swi_clr));
endmodule

// File: rtl/irq_group.sv
module irq_group
    import irq_steer_pkg::*;
#(
    parameter int unsigned W     = 4,
    parameter int unsigned BASE  = 0,
    parameter int unsigned IDW   = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   req_i,
    input  logic           take_i,
    output logic [IDW-1:0] id_o,
    output logic           ack_o
);
    localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1;

    grp_state_e state_q;
    grp_state_e state_n;
    logic       any_req;

    assign any_req = |req_i;

    // lowest-numbered active line wins; scanned from the top down
    always_comb begin
        id_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req_i[i]) id_o = IDW'(BASE + i);
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            GRP_IDLE: if (any_req) state_n = GRP_PEND;
            GRP_PEND: begin
                if (take_i)        state_n = GRP_ACK;
                else if (!any_req) state_n = GRP_IDLE;
            end
            GRP_ACK:  state_n = any_req ? GRP_PEND : GRP_IDLE;
            default:  state_n = GRP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= GRP_IDLE;
        else     state_q <= state_n;
    end

    always_comb begin
        ack_o = (state_q == GRP_ACK);
    end

    logic [IDX_W-1:0] id_off;
    assign id_off = IDX_W'(id_o - IDW'(BASE));

    assert_ack_single_R8: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o);

    assert_ack_after_take_R8: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> $past(take_i));

    assert_no_ack_from_idle_R9: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> ($past(state_q) == GRP_PEND));

    assert_id_points_at_req_R7: assert property (@(posedge clk) disable iff (rst)
        any_req |-> req_i[id_off]);
endmodule

// File: rtl/irq_steer_top.sv
module irq_steer_top
    import irq_steer_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   irq_in,
    input  logic [NUM_SRC-1:0]   reg_wdata,
    input  logic                 swi_set_stb,
    input  logic                 swi_clr_stb,
    input  logic                 en_set_stb,
    input  logic                 fast_take,
    input  logic                 gen_take,
    output logic [NUM_SRC-1:0]   raw_status,
    output logic [NUM_SRC-1:0]   swi_value,
    output logic [NUM_SRC-1:0]   en_value,
    output logic [FAST_N-1:0]    fast_status,
    output logic [NUM_SRC-FAST_N-1:0] gen_status,
    output logic [ID_W-1:0]      fast_id,
    output logic [ID_W-1:0]      gen_id,
    output logic                 fast_ack,
    output logic                 gen_ack
);
    localparam int unsigned GEN_N = NUM_SRC - FAST_N;

    logic [NUM_SRC-1:0] masked;

    irq_src_regs #(.N(NUM_SRC)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wdata   (reg_wdata),
        .swi_set (swi_set_stb),
        .swi_clr (swi_clr_stb),
        .en_set  (en_set_stb),
        .swi_q   (swi_value),
        .en_q    (en_value)
    );

    always_comb begin
        raw_status  = irq_in | swi_value;
        masked      = raw_status & en_value;
        fast_status = masked[FAST_N-1:0];
        gen_status  = masked[NUM_SRC-1:FAST_N];
    end

    irq_group #(.W(FAST_N), .BASE(0), .IDW(ID_W)) u_fast (
        .clk    (clk),
        .rst    (rst),
        .req_i  (fast_status),
        .take_i (fast_take),
        .id_o   (fast_id),
        .ack_o  (fast_ack)
    );

    irq_group #(.W(GEN_N), .BASE(FAST_N), .IDW(ID_W)) u_gen (
        .clk    (clk),
        .rst    (rst),
        .req_i  (gen_status),
        .take_i (gen_take),
        .id_o   (gen_id),
        .ack_o  (gen_ack)
    );

    assert_mask_gate_R6: assert property (@(posedge clk) disable iff (rst)
        ((({gen_status, fast_status}) & ~en_value) == '0));

    assert_raw_covers_swi_R1: assert property (@(posedge clk) disable iff (rst)
        ((raw_status & swi_value) == swi_value));
endmodule

// File: tb/sim_irq_steer_top.sv
`timescale 1ns/1ps
module sim_irq_steer_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] irq_in, reg_wdata;
    logic        swi_set_stb, swi_clr_stb, en_set_stb, fast_take, gen_take;
    logic [31:0] raw_status, swi_value, en_value;
    logic [3:0]  fast_status;
    logic [27:0] gen_status;
    logic [4:0]  fast_id, gen_id;
    logic        fast_ack, gen_ack;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_steer_top u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in), .reg_wdata(reg_wdata),
        .swi_set_stb(swi_set_stb), .swi_clr_stb(swi_clr_stb), .en_set_stb(en_set_stb),
        .fast_take(fast_take), .gen_take(gen_take),
        .raw_status(raw_status), .swi_value(swi_value), .en_value(en_value),
        .fast_status(fast_status), .gen_status(gen_status),
        .fast_id(fast_id), .gen_id(gen_id), .fast_ack(fast_ack), .gen_ack(gen_ack)
    );

    // rows: {irq_in, enable write, software set write}
    localparam logic [95:0] TBL [8] = '{
        {32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000},
        {32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000},
        {32'h0000_0030, 32'h0000_0020, 32'h0000_0000},
        {32'h0000_0000, 32'h0000_0F00, 32'h0000_0C00},
        {32'h0000_000C, 32'h0001_0008, 32'h0001_0000},
        {32'hFFFF_FFF0, 32'h0000_0000, 32'h0000_0000},
        {32'h0000_0010, 32'hFFFF_FFFF, 32'h0000_0002},
        {32'h5555_5555, 32'hAAAA_AAAA, 32'h0000_0002}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        swi_set_stb = 0; swi_clr_stb = 0; en_set_stb = 0;
        fast_take = 0; gen_take = 0; reg_wdata = '0;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic wr(input bit s, input bit c, input bit e, input logic [31:0] d);
        reg_wdata = d; swi_set_stb = s; swi_clr_stb = c; en_set_stb = e;
        tick();
        swi_set_stb = 0; swi_clr_stb = 0; en_set_stb = 0; reg_wdata = '0;
    endtask

    function automatic logic [4:0] low_id(input logic [31:0] m, input int lo, input int hi);
        for (int i = lo; i <= hi; i++) if (m[i]) return 5'(i);
        return 5'd0;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        irq_in = 32'h0000_000A;
        @(negedge clk);
        do_reset();
        #1;
        chk("R5 enable after reset", en_value, 32'h0);
        chk("R5 swi after reset", swi_value, 32'h0);
        chk("R5 acks after reset", {30'd0, fast_ack, gen_ack}, 32'h0);
        chk("R1 raw with no swi", raw_status, 32'h0000_000A);
        chk("R6 fast masked by reset", {28'd0, fast_status}, 32'h0);

        for (int r = 0; r < 8; r++) begin
            logic [31:0] ir, en, sw, raw, m;
            {ir, en, sw} = TBL[r];
            irq_in = '0;
            do_reset();
            wr(0, 0, 1, en);
            wr(1, 0, 0, sw);
            irq_in = ir;
            #1;
            raw = ir | sw;
            m = raw & en;
            chk($sformatf("R1 raw row %0d", r), raw_status, raw);
            chk($sformatf("R6 fast row %0d", r), {28'd0, fast_status}, {28'd0, m[3:0]});
            chk($sformatf("R6 gen row %0d", r), {4'd0, gen_status}, {4'd0, m[31:4]});
            chk($sformatf("R7 fast id row %0d", r), {27'd0, fast_id}, {27'd0, low_id(m, 0, 3)});
            chk($sformatf("R7 gen id row %0d", r), {27'd0, gen_id}, {27'd0, low_id(m, 4, 31)});
        end

        // software register set / clear behaviour
        irq_in = '0;
        do_reset();
        wr(1, 0, 0, 32'h0000_00F0);
        wr(1, 0, 0, 32'h0000_0001);
        #1 chk("R2 zero bits keep swi", swi_value, 32'h0000_00F1);
        wr(0, 1, 0, 32'h0000_0010);
        #1 chk("R3 clear strobe", swi_value, 32'h0000_00E1);
        wr(1, 1, 0, 32'h0000_0300);
        #1 chk("R3 set wins over clear", swi_value, 32'h0000_03E1);
        wr(0, 1, 0, 32'h0000_03E1);
        #1 chk("R3 clear all", swi_value, 32'h0);

        // enable register is set-only
        wr(0, 0, 1, 32'h0000_000F);
        wr(0, 0, 1, 32'h0000_0000);
        #1 chk("R4 zero write keeps enable", en_value, 32'h0000_000F);
        wr(0, 0, 1, 32'h0000_00F0);
        #1 chk("R4 accumulate", en_value, 32'h0000_00FF);
        do_reset();
        #1 chk("R5 reset clears enable", en_value, 32'h0);

        // fast acknowledge pulse
        wr(0, 0, 1, 32'hFFFF_FFFF);
        irq_in = 32'h0000_0001;
        tick();
        fast_take = 1;
        tick();
        fast_take = 0;
        #1 chk("R8 fast ack high", {31'd0, fast_ack}, 32'd1);
        chk("R8 gen ack quiet", {31'd0, gen_ack}, 32'd0);
        tick();
        #1 chk("R8 fast ack one cycle", {31'd0, fast_ack}, 32'd0);

        // take while idle, and take on the cycle the request appears
        irq_in = '0;
        tick();
        gen_take = 1;
        tick();
        gen_take = 0;
        #1 chk("R9 take with no request", {31'd0, gen_ack}, 32'd0);
        irq_in = 32'h0000_0100;
        gen_take = 1;
        tick();
        gen_take = 0;
        #1 chk("R9 take on arrival ignored", {31'd0, gen_ack}, 32'd0);
        gen_take = 1;
        tick();
        gen_take = 0;
        #1 chk("R8 gen ack after pending", {31'd0, gen_ack}, 32'd1);
        chk("R7 gen id bit 8", {27'd0, gen_id}, 32'd8);
        tick();
        #1 chk("R8 gen ack one cycle", {31'd0, gen_ack}, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule